// File: doc/BRIEF.md
# Radix-4 Butterfly with Fixed Twiddle Factors

This block is one radix-4 decimation-in-frequency butterfly for complex fixed-point samples. It accepts four complex samples, each carried as a separate real word and imaginary word. It forms the four-point DFT of those samples and divides every sum by four. It then rotates three of the four results by twiddle factors that are fixed when the instance is elaborated. The first result leaves the block unrotated, because its twiddle is always unity.

A transform is built by placing many instances side by side, stage after stage. Each instance receives its own twiddle triple, W^j, W^2j and W^3j, where W = exp(-i*2*pi/L), L is the span of the stage and j is the index of the group. Routing samples between stages lies outside the block. A parameter adds one optional output register, so that a pipelined stage can be built from the same block.

Top module: `r4bf_top`

## Requirements
- R1: y0 is the unrotated sum term. Each component equals floor((a+b+c+d)/4), computed per component.
- R2: y1 is the term X1 = (a - j*b - c + j*d)/4 multiplied by TW1. Its real sum is a_re+b_im-c_re-d_im and its imaginary sum is a_im-b_re-c_im+d_re, each floored after division by 4.
- R3: y2 is the term X2 = (a - b + c - d)/4 multiplied by TW2. Each component is floored after division by 4.
- R4: y3 is the term X3 = (a + j*b - c - j*d)/4 multiplied by TW3. Its real sum is a_re-b_im-c_re+d_im and its imaginary sum is a_im+b_re-c_im-d_re, each floored.
- R5: The divide-by-4 is an arithmetic right shift by 2, so it rounds toward minus infinity (for example, a_re=-3 with all other inputs zero gives y0_re=-1). For any 18-bit inputs the result always fits the data width.
- R6: A twiddle field is an 18-bit two's complement value with 17 fraction bits, so its value is field/2^17. A rotated output has a real part of (xr*wr - xi*wi + 2^16) >> 17 and an imaginary part of (xr*wi + xi*wr + 2^16) >> 17. The shift is arithmetic, which makes the rounding round-half-up.
- R7: A rotated component that falls outside the data range is clamped to [-2^17, 2^17-1]. For example, a rotation by -1.0j of an X2 real part equal to -2^17 gives an imaginary part of 2^17-1.
- R8: With REG_OUT=1 the outputs follow the inputs after exactly one clock edge. With REG_OUT=0 the outputs follow the inputs in the same cycle, with no clock.
- R9: With REG_OUT=1, a synchronous active-high reset sets all output words to zero on the next edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| a_re | input | DATA_W | Sample a, real part |
| a_im | input | DATA_W | Sample a, imaginary part |
| b_re | input | DATA_W | Sample b, real part |
| b_im | input | DATA_W | Sample b, imaginary part |
| c_re | input | DATA_W | Sample c, real part |
| c_im | input | DATA_W | Sample c, imaginary part |
| d_re | input | DATA_W | Sample d, real part |
| d_im | input | DATA_W | Sample d, imaginary part |
| y0_re | output | DATA_W | Unrotated sum term, real part |
| y0_im | output | DATA_W | Unrotated sum term, imaginary part |
| y1_re | output | DATA_W | Term 1 times TW1, real part |
| y1_im | output | DATA_W | Term 1 times TW1, imaginary part |
| y2_re | output | DATA_W | Term 2 times TW2, real part |
| y2_im | output | DATA_W | Term 2 times TW2, imaginary part |
| y3_re | output | DATA_W | Term 3 times TW3, real part |
| y3_im | output | DATA_W | Term 3 times TW3, imaginary part |

## Verification
The bench builds two copies with DATA_W=18: one with REG_OUT=1 and one with REG_OUT=0. Both get the twiddles TW1 = exp(-i*pi/4), TW2 = exactly -1.0j and TW3 = exp(-i*3*pi/4). Because the -1.0j twiddle is exactly representable, a rotation can leave the data range, which brings clamping within reach. The odd-valued diagonal twiddles exercise non-trivial rounding. Each input word is swept on its own over 16 values that include both range limits, and then pseudo-random vectors biased toward the extremes are applied to both copies at once.

// File: rtl/r4bf_pkg.sv
package r4bf_pkg;

    // Twiddle word format: sign bit plus fraction bits.
    localparam int TWF_W    = 18;
    localparam int TWF_FRAC = TWF_W - 1;

    typedef logic signed [TWF_W-1:0] twf_t;

    typedef struct packed {
        twf_t re;
        twf_t im;
    } twf_pair_t;

    // Largest positive twiddle value (just under 1.0), used as a default.
    localparam twf_pair_t TWF_NEAR_ONE = '{re: twf_t'((1 <<< TWF_FRAC) - 1), im: twf_t'(0)};

endpackage

// File: rtl/r4bf_core.sv
module r4bf_core #(
    parameter int DATA_W = 18
) (
    input  logic signed [DATA_W-1:0] x_re [4],
    input  logic signed [DATA_W-1:0] x_im [4],
    output logic signed [DATA_W-1:0] y_re [4],
    output logic signed [DATA_W-1:0] y_im [4]
);
    localparam int SUM_W = DATA_W + 2;

    logic signed [SUM_W-1:0] e_re [4];
    logic signed [SUM_W-1:0] e_im [4];
    logic signed [SUM_W-1:0] s_re [4];
    logic signed [SUM_W-1:0] s_im [4];

    for (genvar i = 0; i < 4; i++) begin : g_ext
        assign e_re[i] = SUM_W'(x_re[i]);
        assign e_im[i] = SUM_W'(x_im[i]);
    end

    // Four-point DFT. Multiplying by +/-j swaps the parts and changes one sign.
    always_comb begin
        s_re[0] = e_re[0] + e_re[1] + e_re[2] + e_re[3];
        s_im[0] = e_im[0] + e_im[1] + e_im[2] + e_im[3];
        s_re[1] = e_re[0] + e_im[1] - e_re[2] - e_im[3];
        s_im[1] = e_im[0] - e_re[1] - e_im[2] + e_re[3];
        s_re[2] = e_re[0] - e_re[1] + e_re[2] - e_re[3];
        s_im[2] = e_im[0] - e_im[1] + e_im[2] - e_im[3];
        s_re[3] = e_re[0] - e_im[1] - e_re[2] + e_im[3];
        s_im[3] = e_im[0] + e_re[1] - e_im[2] - e_re[3];
    end

    // Divide by 4 with an arithmetic shift; the result always fits DATA_W.
    for (genvar k = 0; k < 4; k++) begin : g_scale
        assign y_re[k] = DATA_W'(s_re[k] >>> 2);
        assign y_im[k] = DATA_W'(s_im[k] >>> 2);
    end

endmodule

// File: rtl/r4bf_cmul.sv
module r4bf_cmul
    import r4bf_pkg::*;
#(
    parameter int        DATA_W = 18,
    parameter twf_pair_t TW     = TWF_NEAR_ONE
) (
    input  logic signed [DATA_W-1:0] x_re,
    input  logic signed [DATA_W-1:0] x_im,
    output logic signed [DATA_W-1:0] y_re,
    output logic signed [DATA_W-1:0] y_im
);
    localparam int ACC_W = DATA_W + TWF_W + 1;
    localparam twf_t W_RE = TW.re;
    localparam twf_t W_IM = TW.im;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (TWF_FRAC - 1);
    localparam logic signed [ACC_W-1:0] HI   = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] LO   = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [ACC_W-1:0] acc_re, acc_im;

    function automatic logic signed [DATA_W-1:0] round_sat(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] q;
        q = (v + HALF) >>> TWF_FRAC;
        if (q > HI)      q = HI;
        else if (q < LO) q = LO;
        return DATA_W'(q);
    endfunction

    always_comb begin
        acc_re = ACC_W'(x_re) * ACC_W'(W_RE) - ACC_W'(x_im) * ACC_W'(W_IM);
        acc_im = ACC_W'(x_re) * ACC_W'(W_IM) + ACC_W'(x_im) * ACC_W'(W_RE);
    end

    assign y_re = round_sat(acc_re);
    assign y_im = round_sat(acc_im);

endmodule

// File: rtl/r4bf_top.sv
module r4bf_top
    import r4bf_pkg::*;
#(
    parameter int        DATA_W  = 18,
    parameter bit        REG_OUT = 1'b1,
    parameter twf_pair_t TW1     = TWF_NEAR_ONE,
    parameter twf_pair_t TW2     = TWF_NEAR_ONE,
    parameter twf_pair_t TW3     = TWF_NEAR_ONE
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] a_re,
    input  logic signed [DATA_W-1:0] a_im,
    input  logic signed [DATA_W-1:0] b_re,
    input  logic signed [DATA_W-1:0] b_im,
    input  logic signed [DATA_W-1:0] c_re,
    input  logic signed [DATA_W-1:0] c_im,
    input  logic signed [DATA_W-1:0] d_re,
    input  logic signed [DATA_W-1:0] d_im,
    output logic signed [DATA_W-1:0] y0_re,
    output logic signed [DATA_W-1:0] y0_im,
    output logic signed [DATA_W-1:0] y1_re,
    output logic signed [DATA_W-1:0] y1_im,
    output logic signed [DATA_W-1:0] y2_re,
    output logic signed [DATA_W-1:0] y2_im,
    output logic signed [DATA_W-1:0] y3_re,
    output logic signed [DATA_W-1:0] y3_im
);
    logic signed [DATA_W-1:0] in_re [4];
    logic signed [DATA_W-1:0] in_im [4];
    logic signed [DATA_W-1:0] cy_re [4];
    logic signed [DATA_W-1:0] cy_im [4];
    logic signed [DATA_W-1:0] t_re  [4];
    logic signed [DATA_W-1:0] t_im  [4];
    logic signed [DATA_W-1:0] o_re  [4];
    logic signed [DATA_W-1:0] o_im  [4];

    assign in_re[0] = a_re;  assign in_im[0] = a_im;
    assign in_re[1] = b_re;  assign in_im[1] = b_im;
    assign in_re[2] = c_re;  assign in_im[2] = c_im;
    assign in_re[3] = d_re;  assign in_im[3] = d_im;

    r4bf_core #(.DATA_W(DATA_W)) u_core (
        .x_re(in_re), .x_im(in_im), .y_re(cy_re), .y_im(cy_im)
    );

    // Term 0 has a unity twiddle and passes through unrotated.
    assign t_re[0] = cy_re[0];
    assign t_im[0] = cy_im[0];

    for (genvar k = 1; k < 4; k++) begin : g_rot
        localparam twf_pair_t TW_K = (k == 1) ? TW1 : (k == 2) ? TW2 : TW3;
        r4bf_cmul #(.DATA_W(DATA_W), .TW(TW_K)) u_cmul (
            .x_re(cy_re[k]), .x_im(cy_im[k]), .y_re(t_re[k]), .y_im(t_im[k])
        );
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            for (int k = 0; k < 4; k++) begin
                if (rst) begin
                    o_re[k] <= '0;
                    o_im[k] <= '0;
                end else begin
                    o_re[k] <= t_re[k];
                    o_im[k] <= t_im[k];
                end
            end
        end

        // R8: equal inputs make term 0 equal a, one cycle later at the ports
        p_latency_r8: assert property (@(posedge clk) disable iff (rst)
            (a_re == b_re && b_re == c_re && c_re == d_re &&
             a_im == b_im && b_im == c_im && c_im == d_im)
            |=> (y0_re == $past(a_re) && y0_im == $past(a_im)));

        // R9: the edge after reset leaves every output at zero
        p_reset_zero_r9: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (y0_re == '0 && y0_im == '0 && y1_re == '0 && y1_im == '0 &&
                            y2_re == '0 && y2_im == '0 && y3_re == '0 && y3_im == '0));
    end else begin : g_comb
        always_comb begin
            for (int k = 0; k < 4; k++) begin
                o_re[k] = t_re[k];
                o_im[k] = t_im[k];
            end
        end
    end

    assign y0_re = o_re[0];  assign y0_im = o_im[0];
    assign y1_re = o_re[1];  assign y1_im = o_im[1];
    assign y2_re = o_re[2];  assign y2_im = o_im[2];
    assign y3_re = o_re[3];  assign y3_im = o_im[3];

    // R1: with b, c and d at zero, term 0 is a divided by four
    p_lone_a_r1: assert property (@(posedge clk) disable iff (rst)
        (b_re == '0 && b_im == '0 && c_re == '0 && c_im == '0 && d_re == '0 && d_im == '0)
        |-> (t_re[0] == (a_re >>> 2) && t_im[0] == (a_im >>> 2)));

    // R2: four equal samples leave no energy in terms 1 to 3
    p_equal_in_r2: assert property (@(posedge clk) disable iff (rst)
        (a_re == b_re && b_re == c_re && c_re == d_re &&
         a_im == b_im && b_im == c_im && c_im == d_im)
        |-> (cy_re[1] == '0 && cy_im[1] == '0 && cy_re[2] == '0 && cy_im[2] == '0 &&
             cy_re[3] == '0 && cy_im[3] == '0));

    // R6: rounding maps a zero term to zero after every rotation
    p_zero_map_r6: assert property (@(posedge clk) disable iff (rst)
        (cy_re[1] == '0 && cy_im[1] == '0) |-> (t_re[1] == '0 && t_im[1] == '0));

endmodule

// File: tb/r4bf_top_tb.sv
`timescale 1ns/1ps
module r4bf_top_tb;
    import r4bf_pkg::*;

    localparam int DW = 18;
    localparam twf_pair_t TWA = '{re: 18'sd92682,  im: -18'sd92682};
    localparam twf_pair_t TWB = '{re: 18'sd0,      im: -18'sd131072};
    localparam twf_pair_t TWC = '{re: -18'sd92682, im: -18'sd92682};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [DW-1:0] in_re [4];
    logic signed [DW-1:0] in_im [4];
    logic signed [DW-1:0] r_re [4], r_im [4];
    logic signed [DW-1:0] z_re [4], z_im [4];

    longint ex_re [4], ex_im [4];
    int n_chk = 0, n_bad = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    r4bf_top #(.DATA_W(DW), .REG_OUT(1'b1), .TW1(TWA), .TW2(TWB), .TW3(TWC)) u_dut (
        .clk(clk), .rst(rst),
        .a_re(in_re[0]), .a_im(in_im[0]), .b_re(in_re[1]), .b_im(in_im[1]),
        .c_re(in_re[2]), .c_im(in_im[2]), .d_re(in_re[3]), .d_im(in_im[3]),
        .y0_re(r_re[0]), .y0_im(r_im[0]), .y1_re(r_re[1]), .y1_im(r_im[1]),
        .y2_re(r_re[2]), .y2_im(r_im[2]), .y3_re(r_re[3]), .y3_im(r_im[3]));

    r4bf_top #(.DATA_W(DW), .REG_OUT(1'b0), .TW1(TWA), .TW2(TWB), .TW3(TWC)) u_comb (
        .clk(clk), .rst(rst),
        .a_re(in_re[0]), .a_im(in_im[0]), .b_re(in_re[1]), .b_im(in_im[1]),
        .c_re(in_re[2]), .c_im(in_im[2]), .d_re(in_re[3]), .d_im(in_im[3]),
        .y0_re(z_re[0]), .y0_im(z_im[0]), .y1_re(z_re[1]), .y1_im(z_im[1]),
        .y2_re(z_re[2]), .y2_im(z_im[2]), .y3_re(z_re[3]), .y3_im(z_im[3]));

    task automatic chk(input string req, input longint act, input longint expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic longint rnd_sat(input longint p);
        longint v;
        v = (p + 65536) >>> 17;
        if (v > 131071) v = 131071;
        if (v < -131072) v = -131072;
        return v;
    endfunction

    // Reference model written from the requirements
    task automatic model();
        longint ar, ai, br, bi, cr, ci, dr, di;
        longint fr [4], fi [4], wr, wi;
        ar = longint'(in_re[0]); ai = longint'(in_im[0]);
        br = longint'(in_re[1]); bi = longint'(in_im[1]);
        cr = longint'(in_re[2]); ci = longint'(in_im[2]);
        dr = longint'(in_re[3]); di = longint'(in_im[3]);
        fr[0] = (ar + br + cr + dr) >>> 2;  fi[0] = (ai + bi + ci + di) >>> 2;
        fr[1] = (ar + bi - cr - di) >>> 2;  fi[1] = (ai - br - ci + dr) >>> 2;
        fr[2] = (ar - br + cr - dr) >>> 2;  fi[2] = (ai - bi + ci - di) >>> 2;
        fr[3] = (ar - bi - cr + di) >>> 2;  fi[3] = (ai + br - ci - dr) >>> 2;
        ex_re[0] = fr[0]; ex_im[0] = fi[0];
        for (int k = 1; k < 4; k++) begin
            wr = (k == 1) ? longint'(TWA.re) : (k == 2) ? longint'(TWB.re) : longint'(TWC.re);
            wi = (k == 1) ? longint'(TWA.im) : (k == 2) ? longint'(TWB.im) : longint'(TWC.im);
            ex_re[k] = rnd_sat(fr[k] * wr - fi[k] * wi);
            ex_im[k] = rnd_sat(fr[k] * wi + fi[k] * wr);
        end
    endtask

    function automatic string tag(input int k);
        return (k == 0) ? "R1" : (k == 1) ? "R2" : (k == 2) ? "R3" : "R4";
    endfunction

    // Drive at a falling edge, check the unregistered copy, then the registered copy one edge later.
    task automatic apply();
        model();
        #1;
        for (int k = 0; k < 4; k++) begin
            chk({tag(k), " R8 comb re"}, longint'(z_re[k]), ex_re[k]);
            chk({tag(k), " R8 comb im"}, longint'(z_im[k]), ex_im[k]);
        end
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            chk({tag(k), " R8 reg re"}, longint'(r_re[k]), ex_re[k]);
            chk({tag(k), " R8 reg im"}, longint'(r_im[k]), ex_im[k]);
        end
    endtask

    task automatic clear_in();
        for (int i = 0; i < 4; i++) begin
            in_re[i] = '0;
            in_im[i] = '0;
        end
    endtask

    function automatic logic signed [DW-1:0] sweep_val(input int idx);
        case (idx)
            0: return -18'sd131072;  1: return -18'sd131071;  2: return -18'sd65536;  3: return -18'sd4;
            4: return -18'sd3;       5: return -18'sd2;       6: return -18'sd1;      7: return 18'sd0;
            8: return 18'sd1;        9: return 18'sd2;        10: return 18'sd3;      11: return 18'sd4;
            12: return 18'sd5;       13: return 18'sd65535;   14: return 18'sd131070;
            default: return 18'sd131071;
        endcase
    endfunction

    function automatic logic [31:0] step(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    function automatic logic signed [DW-1:0] pick(input logic [31:0] s);
        if (s[31:29] == 3'd0) return -18'sd131072;
        if (s[31:29] == 3'd1) return 18'sd131071;
        return s[DW-1:0];
    endfunction

    initial begin : watchdog
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        clear_in();
        for (int i = 0; i < 4; i++) begin
            in_re[i] = 18'sd1000 + 18'(i);
            in_im[i] = -18'sd777;
        end
        repeat (3) @(negedge clk);
        // R9: reset clears the registered outputs despite live inputs
        for (int k = 0; k < 4; k++) begin
            chk("R9 reset re", longint'(r_re[k]), 0);
            chk("R9 reset im", longint'(r_im[k]), 0);
        end
        rst = 1'b0;
        clear_in();
        apply();

        // R5: floor division, a_re=-3 gives y0_re=-1
        clear_in(); in_re[0] = -18'sd3; apply();
        chk("R5 floor y0_re", longint'(z_re[0]), -1);

        // R6: a_re=4 gives X1=1, rotated by 45 degrees: re=1, im=-1
        clear_in(); in_re[0] = 18'sd4; apply();
        chk("R6 round y1_re", longint'(z_re[1]), 1);
        chk("R6 round y1_im", longint'(z_im[1]), -1);

        // R7: X2 real part of -2^17 rotated by -1.0j clamps the imaginary part
        clear_in();
        in_re[0] = -18'sd131072; in_re[2] = -18'sd131072;
        in_re[1] = 18'sd131071;  in_re[3] = 18'sd131071;
        apply();
        chk("R7 clamp y2_im", longint'(z_im[2]), 131071);
        chk("R7 clamp y2_re", longint'(z_re[2]), 0);

        // Single-word sweep: every input word over 16 values, all others zero
        for (int w = 0; w < 8; w++) begin
            for (int v = 0; v < 16; v++) begin
                clear_in();
                if (w < 4) in_re[w] = sweep_val(v);
                else       in_im[w-4] = sweep_val(v);
                apply();
            end
        end

        // R9: reset in mid-run
        for (int i = 0; i < 4; i++) begin
            in_re[i] = 18'sd5000;
            in_im[i] = -18'sd5000;
        end
        rst = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            chk("R9 midrun re", longint'(r_re[k]), 0);
            chk("R9 midrun im", longint'(r_im[k]), 0);
        end
        rst = 1'b0;

        // Pseudo-random vectors biased toward the range limits
        for (int n = 0; n < 1500; n++) begin
            for (int i = 0; i < 4; i++) begin
                seed = step(seed); in_re[i] = pick(seed);
                seed = step(seed); in_im[i] = pick(seed);
            end
            apply();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule